// File: doc/BRIEF.md
# Receive TDM Stream Distributor

The block takes the receive payload after line decoding and frame alignment, and spreads it over eight serial TDM output streams. Each stream has 32 channels of 8 bits, which gives 256 bit cells per 125 µs frame. The payload arrives as bytes on a parallel write port. Each byte carries an index: 247 clear 64 kb/s channels, four overhead bytes, and one byte that carries the low-rate asynchronous signals. The bytes are kept in a frame store. Each output channel reads its byte from the store at the start of that channel, so a byte that did not arrive in time is sent again with the previous frame's value.

Streams 0 to 6 carry clear channels in all 32 slots. Stream 7 carries the four received overhead bytes, then four status bytes from the local receiver, then one spare slot of all ones, then the last 23 clear channels. Bit timing comes from a bit-cell strobe at 2.048 Mb/s. The frame is aligned to the system frame pulse in controller mode and to the frame pulse recovered from the line in peripheral mode. The block also drives two 8 kHz outputs and one 32 kHz output from the asynchronous byte.

Top module: `rx_tdm_distributor`

## Requirements
- R1: While reset is applied and directly after it, every bit of `st_o` is 1 and the three asynchronous outputs are 0.
- R2: `mode_ctrl_i` selects the frame pulse: 1 uses `sys_fp_i`, 0 uses `line_fp_i`. The selected pulse, sampled on a `bit_en_i` cycle, makes that bit cell bit 7 of channel 0. The other pulse has no effect.
- R3: Each stream sends one bit per `bit_en_i` strobe, MSB first. There are 8 bits per channel and 32 channels per frame, and the frame counter wraps from cell 255 to cell 0 when no pulse is present.
- R4: Stream s, for s from 0 to 6, carries payload index s*32+c in channel c.
- R5: Stream 7, channel c for c from 9 to 31, carries payload index 215+c, which covers indices 224 to 246.
- R6: Stream 7, channels 0 to 3, carry payload indices 247 to 250. Channels 4 to 7 carry `status_i[8k+7:8k]`, where k = c-4.
- R7: Stream 7, channel 8, is all ones.
- R8: A stored byte keeps its value until the same index is written again. A channel with no new byte repeats the previous value.
- R9: Payload index 251 holds the asynchronous signals. Bit 0 drives `async8k_a_o` and bit 1 drives `async8k_b_o`. Both update only at the frame start cell.
- R10: `async32k_o` takes bit 2+q of index 251 at the start of quarter q, that is channels 0, 8, 16 and 24. It does not change between those points.
- R11: A write with `pl_valid_i` low, or with an index of 252 or above, changes no stored byte.
- R12: `st_o` changes only on cycles where `bit_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-cell strobe, one per 2.048 MHz cell |
| mode_ctrl_i | input | 1 | 1 = controller mode, 0 = peripheral mode |
| sys_fp_i | input | 1 | System frame pulse |
| line_fp_i | input | 1 | Frame pulse recovered from the line |
| pl_valid_i | input | 1 | Payload byte valid |
| pl_idx_i | input | 8 | Payload byte index |
| pl_data_i | input | 8 | Payload byte |
| status_i | input | 32 | Four local status bytes |
| st_o | output | 8 | Serial TDM streams, bit s is stream s |
| async8k_a_o | output | 1 | First 8 kHz asynchronous bit |
| async8k_b_o | output | 1 | Second 8 kHz asynchronous bit |
| async32k_o | output | 1 | 32 kHz asynchronous bit |

## Verification
The assertions assume that a frame pulse counts only when it comes together with `bit_en_i`. They also assume that `bit_en_i` is never high on two cycles in a row, so every bit cell spans one strobe and some idle cycles. The stimulus raises the strobe for one cycle in every four. It writes payload bytes only between frames, so the store is stable for the whole frame being checked. It holds `status_i` constant during each captured frame. Misaligned frames are made by giving extra strobes without a pulse, never by changing the strobe spacing.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int N_STREAMS     = 8;
  localparam int CH_PER_STREAM = 32;
  localparam int BITS_PER_CH   = 8;
  localparam int N_CLEAR       = 247;
  localparam int N_OVH         = 4;
  localparam int N_STAT        = 4;
  localparam int ASYNC_IDX     = N_CLEAR + N_OVH;
  localparam int STORE_DEPTH   = ASYNC_IDX + 1;
  localparam int FRAME_BITS    = CH_PER_STREAM * BITS_PER_CH;
  localparam int CNT_W         = $clog2(FRAME_BITS);
  localparam int BIT_W         = $clog2(BITS_PER_CH);
  localparam int CH_W          = CNT_W - BIT_W;
  localparam int IDX_W         = 8;
  localparam int HEAD_CH       = N_OVH + N_STAT;   // spare slot follows the head
  localparam int LAST_S        = N_STREAMS - 1;

  typedef enum logic [1:0] {SRC_STORE, SRC_STATUS, SRC_ONES} src_kind_e;

  typedef struct packed {
    src_kind_e          kind;
    logic [IDX_W-1:0]   idx;
  } src_t;

  function automatic src_t map_src(int s, logic [CH_W-1:0] ch);
    src_t r;
    int   c;
    c = int'(ch);
    r.kind = SRC_STORE;
    r.idx  = '0;
    if (s < LAST_S) begin
      r.idx = IDX_W'(s * CH_PER_STREAM + c);
    end else if (c < N_OVH) begin
      r.idx = IDX_W'(N_CLEAR + c);
    end else if (c < HEAD_CH) begin
      r.kind = SRC_STATUS;
      r.idx  = IDX_W'(c - N_OVH);
    end else if (c == HEAD_CH) begin
      r.kind = SRC_ONES;
    end else begin
      r.idx = IDX_W'(LAST_S * CH_PER_STREAM + c - (HEAD_CH + 1));
    end
    return r;
  endfunction
endpackage

// File: rtl/rxd_frame_timer.sv
module rxd_frame_timer
  import rxd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             mode_ctrl_i,
  input  logic             sys_fp_i,
  input  logic             line_fp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             load_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             fp_sel;

  assign fp_sel = mode_ctrl_i ? sys_fp_i : line_fp_i;
  assign nxt_o  = fp_sel ? '0 : cnt_q + 1'b1;
  assign load_o = bit_en_i && (nxt_o[BIT_W-1:0] == '0);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '1;
    else if (bit_en_i) cnt_q <= nxt_o;
  end

  // R2
  fp_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && (mode_ctrl_i ? sys_fp_i : line_fp_i) |=> cnt_q == '0);
  // R3
  cell_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && !(mode_ctrl_i ? sys_fp_i : line_fp_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R3
  cell_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(cnt_q));
endmodule

// File: rtl/rxd_payload_store.sv
module rxd_payload_store
  import rxd_pkg::*;
#(
  parameter int DEPTH = STORE_DEPTH,
  parameter int PORTS = N_STREAMS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [7:0]                  wr_data_i,
  input  logic [PORTS-1:0][IDX_W-1:0] rd_idx_i,
  output logic [PORTS-1:0][7:0]       rd_data_o,
  output logic [7:0]                  async_byte_o
);
  logic [7:0] mem_q [DEPTH];
  logic       wr_ok;

  assign wr_ok = wr_en_i && (int'(wr_idx_i) < DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_ok) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    assign rd_data_o[p] = (int'(rd_idx_i[p]) < DEPTH) ? mem_q[rd_idx_i[p]] : 8'hFF;
  end

  assign async_byte_o = mem_q[ASYNC_IDX];

  // R11
  store_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (int'(wr_idx_i) < DEPTH) |=> mem_q[$past(wr_idx_i)] == $past(wr_data_i));
  // R8
  store_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mem_q[ASYNC_IDX]));
endmodule

// File: rtl/rxd_stream_shifter.sv
module rxd_stream_shifter
  import rxd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       load_i,
  input  logic [7:0] load_byte_i,
  output logic       ser_o
);
  logic [7:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '1;
    else if (load_i)   sh_q <= load_byte_i;
    else if (bit_en_i) sh_q <= {sh_q[6:0], 1'b1};
  end

  assign ser_o = sh_q[7];

  // R12
  ser_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(ser_o));
  // R3
  ser_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ser_o == $past(load_byte_i[7]));
endmodule

// File: rtl/rx_tdm_distributor.sv
module rx_tdm_distributor
  import rxd_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_en_i,
  input  logic                 mode_ctrl_i,
  input  logic                 sys_fp_i,
  input  logic                 line_fp_i,
  input  logic                 pl_valid_i,
  input  logic [IDX_W-1:0]     pl_idx_i,
  input  logic [7:0]           pl_data_i,
  input  logic [N_STAT*8-1:0]  status_i,
  output logic [N_STREAMS-1:0] st_o,
  output logic                 async8k_a_o,
  output logic                 async8k_b_o,
  output logic                 async32k_o
);
  logic [CNT_W-1:0]                cnt, nxt;
  logic                            load;
  logic [N_STREAMS-1:0][IDX_W-1:0] rd_idx;
  logic [N_STREAMS-1:0][7:0]       rd_data;
  logic [7:0]                      async_byte;
  logic                            frame_start, quarter_start;
  logic [2:0]                      q_bit;

  rxd_frame_timer u_timer (
    .clk_i, .rst_ni, .bit_en_i, .mode_ctrl_i, .sys_fp_i, .line_fp_i,
    .cnt_o(cnt), .nxt_o(nxt), .load_o(load)
  );

  rxd_payload_store u_store (
    .clk_i, .rst_ni,
    .wr_en_i(pl_valid_i), .wr_idx_i(pl_idx_i), .wr_data_i(pl_data_i),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .async_byte_o(async_byte)
  );

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_st
    src_t       src;
    logic [7:0] byte_sel;

    assign src       = map_src(s, nxt[CNT_W-1:BIT_W]);
    assign rd_idx[s] = src.idx;

    always_comb begin
      unique case (src.kind)
        SRC_STATUS: byte_sel = status_i[src.idx[1:0]*8 +: 8];
        SRC_ONES:   byte_sel = 8'hFF;
        default:    byte_sel = rd_data[s];
      endcase
    end

    rxd_stream_shifter u_sh (
      .clk_i, .rst_ni, .bit_en_i, .load_i(load),
      .load_byte_i(byte_sel), .ser_o(st_o[s])
    );
  end

  assign frame_start   = bit_en_i && (nxt == '0);
  assign quarter_start = bit_en_i && (nxt[CNT_W-3:0] == '0);
  assign q_bit         = {1'b0, nxt[CNT_W-1 -: 2]} + 3'd2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      async8k_a_o <= 1'b0;
      async8k_b_o <= 1'b0;
      async32k_o  <= 1'b0;
    end else begin
      if (frame_start) begin
        async8k_a_o <= async_byte[0];
        async8k_b_o <= async_byte[1];
      end
      if (quarter_start) async32k_o <= async_byte[q_bit];
    end
  end

  // R7
  spare_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt[CNT_W-1:BIT_W] == CH_W'(HEAD_CH) |-> st_o[LAST_S]);
  // R9
  async8k_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_en_i && nxt == '0) |=> $stable(async8k_a_o) && $stable(async8k_b_o));
  // R10
  async32k_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_en_i && nxt[CNT_W-3:0] == '0) |=> $stable(async32k_o));
endmodule

// File: tb/rx_tdm_distributor_tb.sv
module rx_tdm_distributor_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_en_i = 1'b0;
  logic        mode_ctrl_i = 1'b1;
  logic        sys_fp_i = 1'b0;
  logic        line_fp_i = 1'b0;
  logic        pl_valid_i = 1'b0;
  logic [7:0]  pl_idx_i = '0;
  logic [7:0]  pl_data_i = '0;
  logic [31:0] status_i = '0;
  logic [7:0]  st_o;
  logic        async8k_a_o, async8k_b_o, async32k_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m [252];
  logic       rec [8][256];

  always #2.5 clk_i = ~clk_i;

  rx_tdm_distributor dut_i (
    .clk_i, .rst_ni, .bit_en_i, .mode_ctrl_i, .sys_fp_i, .line_fp_i,
    .pl_valid_i, .pl_idx_i, .pl_data_i, .status_i,
    .st_o, .async8k_a_o, .async8k_b_o, .async32k_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int s, int c);
    if (s < 7)  return m[s*32 + c];
    if (c < 4)  return m[247 + c];
    if (c < 8)  return status_i[(c-4)*8 +: 8];
    if (c == 8) return 8'hFF;
    return m[215 + c];
  endfunction

  task automatic wr(input int idx, input logic [7:0] d, input bit v);
    @(negedge clk_i);
    pl_valid_i = v; pl_idx_i = 8'(idx); pl_data_i = d;
    @(negedge clk_i);
    pl_valid_i = 1'b0;
    if (v && idx < 252) m[idx] = d;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); bit_en_i = 1'b1;
      @(negedge clk_i); bit_en_i = 1'b0;
      @(negedge clk_i); @(negedge clk_i);
    end
  endtask

  // Runs 256 cells with a pulse on cell 0 and compares against the model shifted by off cells
  task automatic capture(input bit sys_p, input bit line_p, input int off, input string tag);
    int hold_bad = 0;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] snap;
      @(negedge clk_i);
      bit_en_i = 1'b1;
      sys_fp_i = sys_p && (i == 0);
      line_fp_i = line_p && (i == 0);
      @(negedge clk_i);
      bit_en_i = 1'b0; sys_fp_i = 1'b0; line_fp_i = 1'b0;
      for (int s = 0; s < 8; s++) rec[s][i] = st_o[s];
      snap = st_o;
      if (off == 0 && i == 0) begin
        check(async8k_a_o == m[251][0], "R9 a", int'(async8k_a_o), int'(m[251][0]));
        check(async8k_b_o == m[251][1], "R9 b", int'(async8k_b_o), int'(m[251][1]));
      end
      if (off == 0 && i % 64 == 0)
        check(async32k_o == m[251][2 + i/64], "R10", int'(async32k_o), int'(m[251][2 + i/64]));
      @(negedge clk_i);
      if (st_o != snap) hold_bad++;
      @(negedge clk_i);
    end
    check(hold_bad == 0, "R12", hold_bad, 0);
    for (int s = 0; s < 8; s++) begin
      int bad_lo = 0, bad_mid = 0, bad_hi = 0, first = -1;
      for (int i = 0; i < 256; i++) begin
        int p = (i + off) % 256;
        logic e = exp_byte(s, p/8)[7 - p%8];
        if (rec[s][i] !== e) begin
          if (first < 0) first = i;
          if (s < 7 || p/8 < 8) bad_lo++;
          else if (p/8 == 8) bad_mid++;
          else bad_hi++;
        end
      end
      if (s < 7) check(bad_lo == 0, $sformatf("%s/R4 stream %0d cell %0d", tag, s, first), bad_lo, 0);
      else begin
        check(bad_lo == 0, $sformatf("%s/R6 stream 7 cell %0d", tag, first), bad_lo, 0);
        check(bad_mid == 0, $sformatf("%s/R7 stream 7", tag), bad_mid, 0);
        check(bad_hi == 0, $sformatf("%s/R5 stream 7 cell %0d", tag, first), bad_hi, 0);
      end
    end
  endtask

  function automatic logic [7:0] rec_byte(int s, int c);
    logic [7:0] b;
    for (int j = 0; j < 8; j++) b[7-j] = rec[s][c*8 + j];
    return b;
  endfunction

  task automatic t_reset();
    for (int i = 0; i < 252; i++) m[i] = '0;
    repeat (3) @(negedge clk_i);
    check(st_o == 8'hFF, "R1 streams", int'(st_o), 'hFF);
    check({async8k_a_o, async8k_b_o, async32k_o} == 3'b000, "R1 async",
          int'({async8k_a_o, async8k_b_o, async32k_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(st_o == 8'hFF, "R1 after release", int'(st_o), 'hFF);
  endtask

  task automatic t_basic();
    for (int i = 0; i < 252; i++) wr(i, 8'((i * 37 + 11) ^ (i >> 2)), 1'b1);
    wr(251, 8'b0010_1001, 1'b1);   // async: a=1, b=0, quarters 0,1,0,1
    status_i = 32'hC3_5A_96_0F;
    mode_ctrl_i = 1'b1;
    capture(1'b1, 1'b0, 0, "ctrl");
    for (int i = 0; i < 252; i++) wr(i, 8'(~(i * 53 + 7)), 1'b1);
    wr(251, 8'b0001_0110, 1'b1);   // a=0, b=1, quarters 1,0,1,0
    status_i = 32'h01_80_FF_24;
    capture(1'b1, 1'b0, 0, "ctrl2");
  endtask

  task automatic t_repeat_ignore();
    logic [7:0] old5, old_last;
    old5 = m[5];
    old_last = m[246];
    wr(0, 8'h3C, 1'b1);
    wr(100, 8'hE1, 1'b1);
    wr(5, ~old5, 1'b0);          // valid low: dropped
    for (int k = 252; k < 256; k++) wr(k, 8'h00, 1'b1);  // out of range: dropped
    capture(1'b1, 1'b0, 0, "rep");
    check(rec_byte(0, 0) == 8'h3C, "R8 new byte", int'(rec_byte(0, 0)), 'h3C);
    check(rec_byte(0, 5) == old5, "R11 valid low", int'(rec_byte(0, 5)), int'(old5));
    check(rec_byte(7, 31) == old_last, "R8 repeat", int'(rec_byte(7, 31)), int'(old_last));
    check(rec_byte(7, 3) == m[250], "R11 index range", int'(rec_byte(7, 3)), int'(m[250]));
  endtask

  task automatic t_mode();
    mode_ctrl_i = 1'b0;
    steps(6);                         // counter now one past cell 5
    capture(1'b1, 1'b0, 6, "R2 sys ignored/R3");
    capture(1'b0, 1'b1, 0, "R2 line");
    mode_ctrl_i = 1'b1;
    steps(3);
    capture(1'b0, 1'b1, 3, "R2 line ignored/R3");
    capture(1'b1, 1'b0, 0, "R2 sys");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_repeat_ignore();
    t_mode();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule